// File: doc/BRIEF.md
# Serial Readout Sequencer for a 16-bit Converter

This block is the digital control of a single-channel 16-bit converter. It runs a fixed three-phase cycle: a timed conversion, a sleep phase that keeps the result, and a serial readout. When the conversion timer expires, it takes the result from a stub conversion source. It clamps the value into the 16-bit output range and keeps it until a host reads it out.

The host uses three wires: an active-low chip select, a serial clock that the host drives, and a three-state data line. The block brings both inputs into its own clock domain and acts on their synchronized levels and edges. During sleep, a low-power flag tells the rest of the chip that the analog section may power down. The synchronous reset acts as the power-on reset. It holds the block in a clearing phase for a fixed number of cycles and then starts the first conversion.

Top module: `serial_readout_seq`

## Requirements
- R1: While `rst` is high, `sdo`, `sdo_oe` and `low_power` are 0. After `rst` falls, the block stays in a power-on phase for POR_CYC cycles, then converts for CONV_CYC cycles, then sleeps. `low_power` rises (with `cs_n` high) POR_CYC+CONV_CYC+1 cycles after the first clock edge following reset.
- R2: A conversion lasts exactly CONV_CYC cycles. Chip select and serial clock activity during a conversion, including both being low together, neither ends it nor restarts it.
- R3: The block leaves sleep for readout only when the synchronized chip select and serial clock are low at the same time. Either one alone being low keeps it in sleep.
- R4: On entry to readout, `sdo` carries bit 15 of the held result. Each later falling edge of the serial clock presents the next lower bit, so the word leaves MSB first.
- R5: The 16th falling serial clock edge of a readout ends it and starts a new conversion.
- R6: A rising edge of chip select during readout ends it at once and starts a new conversion.
- R7: `sdo_oe` is 1 exactly while the synchronized chip select is low, three clock cycles behind the pin.
- R8: `low_power` is 1 only in sleep while chip select is high. It is 0 in sleep once chip select goes low with the serial clock high.
- R9: The held result does not change while the block sleeps, however long the sleep lasts and whatever the conversion source does.
- R10: `raw_code` is a two's-complement value. Negative values give result 0, values above 65535 give 65535, and anything else passes through unchanged.
- R11: Outside readout, `sdo` is 1 during the power-on and conversion phases (busy) and 0 in sleep (result ready).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| raw_code | input | RAW_W | Two's-complement code from the conversion source, sampled when a conversion ends |
| sdo | output | 1 | Serial data / busy indication |
| sdo_oe | output | 1 | Output enable for the three-state data pad |
| low_power | output | 1 | Sleep-state power-down flag |

## Verification
The bench builds the block with CONV_CYC = 40 and POR_CYC = 12, leaving DATA_W = 16 and an 18-bit raw input. These short windows let dozens of full convert–sleep–readout cycles fit in a short run. They also let the end of each conversion be checked at exact cycle offsets, which exposes any abort or restart caused by host activity. The 18-bit raw width reaches both saturation limits and the most negative code. The sweep also covers the boundary codes and a spread of computed patterns, each read out in full over the serial port.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    PH_POR   = 2'd0,
    PH_CONV  = 2'd1,
    PH_SLEEP = 2'd2,
    PH_DOUT  = 2'd3
  } phase_t;

endpackage

// File: rtl/srs_pin_sync.sv
module srs_pin_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
      last  <= IDLE;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;

endmodule

// File: rtl/srs_conv_src.sv
module srs_conv_src #(
  parameter int DATA_W   = 16,
  parameter int RAW_W    = 18,
  parameter int CONV_CYC = 796800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RAW_W-1:0]  raw,
  output logic              done,
  output logic [DATA_W-1:0] code
);

  localparam int CW = $clog2(CONV_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == CW'(CONV_CYC - 1));

  always_comb begin
    if (raw[RAW_W-1]) begin
      code = '0;
    end else if (|raw[RAW_W-2:DATA_W]) begin
      code = '1;
    end else begin
      code = raw[DATA_W-1:0];
    end
  end

  AST_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (cnt == '0)) else $error("timer not cleared"); // R2

endmodule

// File: rtl/srs_result_shift.sv
module srs_result_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              start,
  input  logic              step,
  output logic              bit_o,
  output logic              last_bit
);

  localparam int IW = $clog2(DATA_W);

  logic [DATA_W-1:0] hold;
  logic [IW-1:0]     idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (load) begin
      hold <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (start) begin
      idx <= IW'(DATA_W - 1);
    end else if (step && (idx != '0)) begin
      idx <= idx - 1'b1;
    end
  end

  assign bit_o    = hold[idx];
  assign last_bit = (idx == '0);

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(hold)) else $error("held result changed"); // R9

endmodule

// File: rtl/serial_readout_seq.sv
module serial_readout_seq #(
  parameter int DATA_W   = 16,
  parameter int RAW_W    = 18,
  parameter int CONV_CYC = 796800,
  parameter int POR_CYC  = 24000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RAW_W-1:0] raw_code,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             low_power
);

  import srs_pkg::*;

  localparam int PW = $clog2(POR_CYC + 1);

  phase_t            phase, phase_nx;
  logic [PW-1:0]     pcnt;
  logic              por_done;
  logic              cs_lvl, cs_rise, cs_fall;
  logic              sck_lvl, sck_rise, sck_fall;
  logic              conv_done;
  logic [DATA_W-1:0] conv_code;
  logic              shift_start, shift_step;
  logic              cur_bit, last_bit;

  srs_pin_sync #(.STAGES(2), .IDLE(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .pin(cs_n),
    .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );

  srs_pin_sync #(.STAGES(2), .IDLE(1'b1)) u_sck_sync (
    .clk(clk), .rst(rst), .pin(sclk),
    .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall)
  );

  srs_conv_src #(.DATA_W(DATA_W), .RAW_W(RAW_W), .CONV_CYC(CONV_CYC)) u_conv (
    .clk(clk), .rst(rst), .run(phase == PH_CONV), .raw(raw_code),
    .done(conv_done), .code(conv_code)
  );

  srs_result_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(conv_done), .din(conv_code),
    .start(shift_start), .step(shift_step),
    .bit_o(cur_bit), .last_bit(last_bit)
  );

  // power-on phase timer
  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else if (phase == PH_POR && !por_done) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign por_done = (phase == PH_POR) && (pcnt == PW'(POR_CYC - 1));

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_POR:   if (por_done) phase_nx = PH_CONV;
      PH_CONV:  if (conv_done) phase_nx = PH_SLEEP;
      PH_SLEEP: if (!cs_lvl && !sck_lvl) phase_nx = PH_DOUT;
      PH_DOUT: begin
        if (cs_rise) begin
          phase_nx = PH_CONV;
        end else if (sck_fall && last_bit) begin
          phase_nx = PH_CONV;
        end
      end
      default:  phase_nx = PH_POR;
    endcase
  end

  assign shift_start = (phase == PH_SLEEP) && (phase_nx == PH_DOUT);
  assign shift_step  = (phase == PH_DOUT) && sck_fall && !cs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_POR;
    end else begin
      phase <= phase_nx;
    end
  end

  // registered pad-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      low_power <= 1'b0;
    end else begin
      unique case (phase)
        PH_DOUT:  sdo <= cur_bit;
        PH_SLEEP: sdo <= 1'b0;
        default:  sdo <= 1'b1;
      endcase
      sdo_oe    <= !cs_lvl;
      low_power <= (phase == PH_SLEEP) && cs_lvl;
    end
  end

  AST_CONV_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONV && !conv_done) |=> (phase == PH_CONV)) else $error("conversion cut short"); // R2

  AST_WAIT_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SLEEP && (cs_lvl || sck_lvl)) |=> (phase == PH_SLEEP)) else $error("early readout"); // R3

  AST_ABORT_ON_CS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DOUT && cs_rise) |=> (phase == PH_CONV)) else $error("abort missed"); // R6

  AST_LAST_EDGE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DOUT && sck_fall && last_bit) |=> (phase == PH_CONV)) else $error("readout overrun"); // R5

  AST_OE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> sdo_oe) else $error("oe not raised"); // R7

  AST_LP_SLEEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_SLEEP) |=> !low_power) else $error("low power outside sleep"); // R8

endmodule

// File: tb/serial_readout_seq_tb_top.sv
module serial_readout_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int RAW_W      = 18;
  localparam int CONV_CYC   = 40;
  localparam int POR_CYC    = 12;
  localparam int NSWEEP     = 40;

  logic             clk = 1'b0;
  logic             rst;
  logic             cs_n;
  logic             sclk;
  logic [RAW_W-1:0] raw_code;
  logic             sdo, sdo_oe, low_power;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_readout_seq #(
    .DATA_W(DATA_W), .RAW_W(RAW_W), .CONV_CYC(CONV_CYC), .POR_CYC(POR_CYC)
  ) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .raw_code(raw_code),
    .sdo(sdo), .sdo_oe(sdo_oe), .low_power(low_power)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sat(input logic [RAW_W-1:0] r);
    int v;
    v = r[RAW_W-1] ? int'(r) - (1 << RAW_W) : int'(r);
    if (v < 0) return 16'd0;
    if (v > 65535) return 16'hFFFF;
    return v[15:0];
  endfunction

  function automatic logic [RAW_W-1:0] code_at(input int i);
    case (i)
      0: return 18'h3FFFF;
      1: return 18'h00000;
      2: return 18'h00001;
      3: return 18'h0FFFF;
      4: return 18'h10000;
      5: return 18'h1FFFF;
      6: return 18'h20000;
      7: return 18'h0FFFE;
      8: return 18'h08000;
      9: return 18'h07FFF;
      default: return RAW_W'((i * 40503) ^ (i << 3));
    endcase
  endfunction

  // Full readout from sleep with cs_n high; loads nxt as the next raw code
  // at the final edge, then waits through the conversion and checks its length.
  task automatic read_word(input logic [RAW_W-1:0] nxt, output logic [15:0] w);
    chk("R8 low_power in sleep with cs high", low_power, 1);
    cs_n = 1'b0; sclk = 1'b1;
    tick(6);
    chk("R7 sdo_oe with cs low", sdo_oe, 1);
    chk("R8 low_power cleared by cs low", low_power, 0);
    chk("R11 sdo ready low in sleep", sdo, 0);
    sclk = 1'b0;
    tick(6);
    w[15] = sdo;
    for (int i = 14; i >= 0; i--) begin
      sclk = 1'b1; tick(3);
      sclk = 1'b0; tick(6);
      w[i] = sdo;
    end
    sclk = 1'b1; tick(3);
    sclk = 1'b0;
    raw_code = nxt;
    tick(5);
    chk("R5 busy after 16th falling edge", sdo, 1);
    sclk = 1'b1;
    tick(CONV_CYC - 3);
    chk("R2 still converting before CONV_CYC", sdo, 1);
    tick(3);
    chk("R2 conversion ended after CONV_CYC", sdo, 0);
    cs_n = 1'b1;
    tick(4);
    chk("R7 sdo_oe released by cs high", sdo_oe, 0);
  endtask

  initial begin
    logic [15:0] w;
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b1; raw_code = code_at(0);
    tick(5);
    chk("R1 reset sdo", sdo, 0);
    chk("R1 reset sdo_oe", sdo_oe, 0);
    chk("R1 reset low_power", low_power, 0);
    rst = 1'b0;
    tick(3);
    chk("R11 busy during power-on phase", sdo, 1);
    tick(POR_CYC + CONV_CYC - 4);
    chk("R1 not yet asleep", low_power, 0);
    tick(4);
    chk("R1 asleep after power-on and first conversion", low_power, 1);

    // sweep of codes: boundaries, saturation, computed patterns
    for (int i = 0; i < NSWEEP; i++) begin
      read_word((i == NSWEEP - 1) ? 18'h0AAAA : code_at(i + 1), w);
      chk("R4 R10 word read MSB first", w, sat(code_at(i)));
    end

    // R3: either line alone low keeps sleep; held result is 0xAAAA
    cs_n = 1'b0; sclk = 1'b1;
    tick(20);
    chk("R3 cs low alone stays asleep", sdo, 0);
    cs_n = 1'b1; sclk = 1'b0;
    tick(20);
    chk("R3 sclk low alone stays asleep", low_power, 1);
    sclk = 1'b1; tick(4);
    cs_n = 1'b0; tick(6);
    sclk = 1'b0; tick(6);
    chk("R3 both low enters readout with bit 15", sdo, 1);
    for (int i = 14; i >= 11; i--) begin
      sclk = 1'b1; tick(3);
      sclk = 1'b0; tick(6);
      chk("R4 partial readout bit", sdo, (16'hAAAA >> i) & 1);
    end

    // R6 abort, then R2 host activity during conversion
    raw_code = 18'h01234;
    cs_n = 1'b1;
    tick(5);
    cs_n = 1'b0; sclk = 1'b1;
    tick(3);
    chk("R6 cs rise started a conversion", sdo, 1);
    repeat (5) begin
      cs_n = 1'b0; sclk = 1'b0; tick(2);
      cs_n = 1'b1; sclk = 1'b1; tick(2);
    end
    cs_n = 1'b0; sclk = 1'b1;
    tick(4);
    chk("R2 host activity did not abort", sdo, 1);
    tick(CONV_CYC + 2 - 32);
    chk("R2 activity did not shorten", sdo, 1);
    tick(4);
    chk("R2 activity did not restart", sdo, 0);

    // R9: long sleep with changing source keeps the result
    cs_n = 1'b1;
    tick(300);
    raw_code = 18'h3FFFF;
    tick(300);
    read_word(18'h0FFFF, w);
    chk("R9 result kept through sleep", w, 16'h1234);
    read_word(18'h00000, w);
    chk("R10 top code passes", w, 16'hFFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule